// File: doc/BRIEF.md
# Routed Level-Interrupt Controller

This block gathers nine level-sensitive interrupt inputs and presents them to a host interrupt controller on three request outputs. Each input first passes through polarity correction. Some inputs have a polarity fixed in hardware, and the rest take their polarity from a shared configuration register. The corrected level is then captured into a pending bit on each output line where that input is enabled.

Each output line has one 32-bit register. Its low field holds the per-input enables, and its upper field holds the pending bits, which are cleared by writing ones. A line's request output is registered and is high while any of its pending bits is also enabled.

The pending field shows every asserted input at once. Host software can therefore scan it from the top bit down to find the highest-numbered cause. A bus master reaches the registers through a single-cycle write strobe with a word address. Read data is returned combinationally from the address.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset, all enables and pending bits are 0, every `irq_o` bit is 0, and the polarity register reads 0x0000_0102. Only the fixed active-high bits are set.
- R2: The polarity register is at offset 0x0. For configurable inputs 0 and 3 to 7, bit n = 1 makes input n active-high, and bit n = 0 makes it active-low.
- R3: Inputs 1 and 8 are always active-high, and input 2 is always active-low. Writes to polarity bits 1, 2 and 8 have no effect, and those bits read back as 1, 0 and 1.
- R4: Line k (k = 0, 1, 2) has its register at offset 0x4 + 4k. Bits 8:0 are the enables of inputs 0 to 8, and they read back as written.
- R5: Pending bit 16+n of line k sets on the clock edge after any cycle in which input n is active and enabled on line k. Several inputs may be pending together.
- R6: An input that is not enabled on a line never sets that line's pending bit.
- R7: Writing 1 to bit 16+n of a line register clears pending bit n of that line, and writing 0 there leaves the bit unchanged. If input n is still active and enabled in the clearing cycle, the bit stays set.
- R8: `irq_o[k]` is registered. It goes high on the clock edge after line k has any pending bit that is also enabled, and it goes low on the clock edge after that condition ends.
- R9: Bits 31:25 and 15:9 of every register read 0. Offsets above 0xC, and addresses that are not word-aligned, read 0 and ignore writes.
- R10: The three lines are independent. Clearing or masking an input on one line does not change its pending bit or enable on any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 9 | Raw interrupt input levels |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 3 | Request outputs toward the host, active-high |

## Verification
The hardest case to reach is an acknowledge that arrives while the input is still active. The bit must then stay pending, yet the same write must clear it once the input has gone away. The stimulus holds an input active, issues a ones-write to its pending bit, and reads the register back. It then drops the input, first writes zeros to that field and reads again, and finally writes the one that clears it. The same input is enabled on two lines, so the bench also shows that an acknowledge on one line leaves the other line's bit in place.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int LIRQ_W = 32;

  // Active level after polarity correction: pol=1 means high is active.
  function automatic logic [LIRQ_W-1:0] lirq_norm(input logic [LIRQ_W-1:0] lvl,
                                                  input logic [LIRQ_W-1:0] pol);
    return ~(lvl ^ pol);
  endfunction

  // Effective polarity: software bits only where configurable, fixed bits forced.
  function automatic logic [LIRQ_W-1:0] lirq_pol_eff(input logic [LIRQ_W-1:0] stored,
                                                     input logic [LIRQ_W-1:0] fix_hi,
                                                     input logic [LIRQ_W-1:0] fix_lo);
    return (stored & ~(fix_hi | fix_lo)) | fix_hi;
  endfunction

  // Next pending value: acknowledge first, then level capture wins.
  function automatic logic [LIRQ_W-1:0] lirq_pend_next(input logic [LIRQ_W-1:0] pend,
                                                       input logic [LIRQ_W-1:0] clr,
                                                       input logic [LIRQ_W-1:0] set);
    return (pend & ~clr) | set;
  endfunction
endpackage

// File: rtl/lirq_polarity.sv
module lirq_polarity
  import lirq_pkg::*;
#(
  parameter int NUM_SRC = 9,
  parameter logic [NUM_SRC-1:0] FIX_HI = 9'h102,
  parameter logic [NUM_SRC-1:0] FIX_LO = 9'h004
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] src,
  output logic [NUM_SRC-1:0] pol_eff,
  output logic [NUM_SRC-1:0] act
);
  logic [NUM_SRC-1:0] stored_q;
  logic [LIRQ_W-1:0]  eff_w, act_w;

  always_ff @(posedge clk) begin
    if (!rst_n)  stored_q <= '0;
    else if (wr) stored_q <= wdata;
  end

  always_comb begin
    eff_w   = lirq_pol_eff(LIRQ_W'(stored_q), LIRQ_W'(FIX_HI), LIRQ_W'(FIX_LO));
    pol_eff = eff_w[NUM_SRC-1:0];
    act_w   = lirq_norm(LIRQ_W'(src), LIRQ_W'(pol_eff));
    act     = act_w[NUM_SRC-1:0];
  end
endmodule

// File: rtl/lirq_line.sv
module lirq_line
  import lirq_pkg::*;
#(
  parameter int NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] act,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic [NUM_SRC-1:0] ack_wdata,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] set_evt,
  output logic [NUM_SRC-1:0] clr_evt,
  output logic               irq_q
);
  logic [LIRQ_W-1:0] nxt_w;

  always_comb begin
    set_evt = act & en_q;
    clr_evt = wr ? ack_wdata : '0;
    nxt_w   = lirq_pend_next(LIRQ_W'(pend_q), LIRQ_W'(clr_evt), LIRQ_W'(set_evt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr) en_q <= en_wdata;
      pend_q <= nxt_w[NUM_SRC-1:0];
      irq_q  <= |(pend_q & en_q);
    end
  end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lirq_pkg::*;
#(
  parameter int NUM_SRC   = 9,
  parameter int NUM_LINES = 3,
  parameter int ADDR_W    = 8,
  parameter int PEND_LSB  = 16,
  parameter logic [NUM_SRC-1:0] FIX_HI = 9'h102,
  parameter logic [NUM_SRC-1:0] FIX_LO = 9'h004
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [LIRQ_W-1:0]    bus_wdata,
  output logic [LIRQ_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int FLAT_W  = NUM_LINES * NUM_SRC;

  logic [IDX_W-1:0]   idx;
  logic               aligned, pol_sel;
  logic [NUM_SRC-1:0] pol_eff, act;
  logic [FLAT_W-1:0]  en_all, pend_all, set_all, clr_all;
  logic [NUM_LINES-1:0] line_sel;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign pol_sel = aligned && (idx == '0);

  lirq_polarity #(.NUM_SRC(NUM_SRC), .FIX_HI(FIX_HI), .FIX_LO(FIX_LO)) u_pol (
    .clk(clk), .rst_n(rst_n), .wr(bus_we && pol_sel),
    .wdata(bus_wdata[NUM_SRC-1:0]), .src(src_i),
    .pol_eff(pol_eff), .act(act)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line_sel[k] = aligned && (idx == IDX_W'(k + 1));
    lirq_line #(.NUM_SRC(NUM_SRC)) u_line (
      .clk(clk), .rst_n(rst_n), .act(act),
      .wr(bus_we && line_sel[k]),
      .en_wdata(bus_wdata[NUM_SRC-1:0]),
      .ack_wdata(bus_wdata[PEND_LSB +: NUM_SRC]),
      .en_q(en_all[k*NUM_SRC +: NUM_SRC]),
      .pend_q(pend_all[k*NUM_SRC +: NUM_SRC]),
      .set_evt(set_all[k*NUM_SRC +: NUM_SRC]),
      .clr_evt(clr_all[k*NUM_SRC +: NUM_SRC]),
      .irq_q(irq_o[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (pol_sel) bus_rdata[NUM_SRC-1:0] = pol_eff;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (line_sel[k]) begin
        bus_rdata[NUM_SRC-1:0]           = en_all[k*NUM_SRC +: NUM_SRC];
        bus_rdata[PEND_LSB +: NUM_SRC]   = pend_all[k*NUM_SRC +: NUM_SRC];
      end
    end
  end
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker #(
  parameter int NUM_SRC   = 9,
  parameter int NUM_LINES = 3,
  parameter logic [NUM_SRC-1:0] FIX_HI = 9'h102,
  parameter logic [NUM_SRC-1:0] FIX_LO = 9'h004
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_LINES-1:0]           irq_o,
  input logic [NUM_SRC-1:0]             pol_eff,
  input logic [NUM_LINES*NUM_SRC-1:0]   en_all,
  input logic [NUM_LINES*NUM_SRC-1:0]   pend_all,
  input logic [NUM_LINES*NUM_SRC-1:0]   set_all,
  input logic [NUM_LINES*NUM_SRC-1:0]   clr_all
);
  AST_FIXED_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_eff & (FIX_HI | FIX_LO)) == FIX_HI); // R3

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_l
    AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[k] == $past(|(pend_all[k*NUM_SRC +: NUM_SRC] & en_all[k*NUM_SRC +: NUM_SRC]))); // R8
  end

  for (genvar i = 0; i < NUM_LINES*NUM_SRC; i++) begin : g_b
    AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_all[i] |=> pend_all[i]); // R5
    AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_all[i]) |-> $past(set_all[i])); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all[i] && !set_all[i]) |=> !pend_all[i]); // R7
  end
endmodule

bind lvl_irq_router lirq_checker #(
  .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .FIX_HI(FIX_HI), .FIX_LO(FIX_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pol_eff(pol_eff),
  .en_all(en_all), .pend_all(pend_all), .set_all(set_all), .clr_all(clr_all)
);

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_i = 9'h004;      // idle: all inactive once configurable inputs are active-high
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;
  int total = 0;
  int bad = 0;

  localparam logic [8:0] IDLE = 9'h004;

  always #4 clk = ~clk;   // 125 MHz

  lvl_irq_router uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clean();
    @(negedge clk); src_i = IDLE;
    wr(8'h04, 32'h01FF_0000);
    wr(8'h08, 32'h01FF_0000);
    wr(8'h0C, 32'h01FF_0000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", {29'd0, irq_o}, 32'd0);
    rd(8'h00, d); check("R1 polarity reset", d, 32'h0000_0102);
    rd(8'h04, d); check("R1 line0 reset", d, 32'd0);
    rd(8'h08, d); check("R1 line1 reset", d, 32'd0);
    rd(8'h0C, d); check("R1 line2 reset", d, 32'd0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(8'h00, 32'h0000_01FF);
    wr(8'h04, 32'hFE00_FE00 | 32'h0A5);
    wr(8'h08, 32'h0000_015A);
    wr(8'h0C, 32'h0000_0003);
    rd(8'h04, d); check("R4/R9 line0 enables, spare bits zero", d, 32'h0000_00A5);
    rd(8'h08, d); check("R4 line1 enables", d, 32'h0000_015A);
    rd(8'h0C, d); check("R4 line2 enables", d, 32'h0000_0003);
    clean();
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R3/R9 polarity all-ones write", d, 32'h0000_01FB);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R3 polarity zero write", d, 32'h0000_0102);
    wr(8'h00, 32'h0000_01FF);
    // R2: input 0 active-high
    wr(8'h04, 32'h1);
    @(negedge clk); src_i[0] = 1'b1;
    rd(8'h04, d); check("R2 input0 high active", d, 32'h0001_0001);
    @(negedge clk); src_i[0] = 1'b0;
    wr(8'h04, 32'h0001_0001);
    rd(8'h04, d); check("R2 input0 low idle after ack", d, 32'h0000_0001);
    wr(8'h00, 32'h0000_01FE);   // input0 active-low, src low -> active
    rd(8'h04, d); check("R2 input0 active-low", d, 32'h0001_0001);
    wr(8'h00, 32'h0000_01FF);
    wr(8'h04, 32'h0001_0001);
    // R3: input 2 stays active-low despite polarity bit 2 = 1
    wr(8'h08, 32'h4);
    @(negedge clk); src_i[2] = 1'b0;
    rd(8'h08, d); check("R3 input2 fixed low", d, 32'h0004_0004);
    @(negedge clk); src_i[2] = 1'b1;
    wr(8'h00, 32'h0);           // try to make input 1 active-low
    wr(8'h08, 32'h0006_0002);
    rd(8'h08, d); check("R3 input1 idle when low", d, 32'h0000_0002);
    @(negedge clk); src_i[1] = 1'b1;
    rd(8'h08, d); check("R3 input1 fixed high", d, 32'h0002_0002);
    wr(8'h00, 32'h0000_01FF);
    clean();
  endtask

  task automatic t_multi_and_mask();
    logic [31:0] d;
    wr(8'h0C, 32'h0000_01FF);
    wr(8'h08, 32'h0000_0010);
    @(negedge clk); src_i = IDLE | 9'h0A9;   // inputs 0,3,5,7
    rd(8'h0C, d); check("R5 several pending", d, 32'h00A9_01FF);
    rd(8'h08, d); check("R6 disabled inputs not captured", d, 32'h0000_0010);
    clean();
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(8'h04, 32'h0000_0040);
    wr(8'h08, 32'h0000_0040);
    @(negedge clk); src_i[6] = 1'b1;
    wr(8'h04, 32'h0040_0040);
    rd(8'h04, d); check("R7 ack while active keeps pending", d, 32'h0040_0040);
    @(negedge clk); src_i[6] = 1'b0;
    wr(8'h04, 32'h0000_0040);
    rd(8'h04, d); check("R7 zero-write leaves pending", d, 32'h0040_0040);
    wr(8'h04, 32'h0040_0040);
    rd(8'h04, d); check("R7 ack clears", d, 32'h0000_0040);
    rd(8'h08, d); check("R10 other line keeps pending", d, 32'h0040_0040);
    wr(8'h08, 32'h0000_0000);
    rd(8'h04, d); check("R10 mask on line1 leaves line0 enable", d, 32'h0000_0040);
    clean();
  endtask

  task automatic t_irq_timing();
    wr(8'h08, 32'h0000_0100);
    @(negedge clk); src_i[8] = 1'b1;
    @(negedge clk);   // pending set at this edge
    check("R8 irq one cycle after pending", {29'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R8 irq asserted", {29'd0, irq_o}, 32'd2);
    src_i[8] = 1'b0;
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'h0000_0000; bus_we = 1'b1;  // mask
    @(negedge clk); bus_we = 1'b0;
    check("R8 irq still high one cycle after mask", {29'd0, irq_o}, 32'd2);
    @(negedge clk);
    check("R8 irq drops after mask", {29'd0, irq_o}, 32'd0);
    clean();
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h06, 32'h0000_01FF);
    rd(8'h10, d); check("R9 offset 0x10 reads zero", d, 32'd0);
    rd(8'h05, d); check("R9 unaligned reads zero", d, 32'd0);
    rd(8'h04, d); check("R9 line0 untouched", d, 32'd0);
    rd(8'h00, d); check("R9 polarity untouched", d, 32'h0000_01FB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_polarity();
    t_multi_and_mask();
    t_ack();
    t_irq_timing();
    t_bad_addr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule